// File: doc/BRIEF.md
# Alarm Status View Bank

This block collects a vector of receiver alarm conditions and presents four views of each one: the live condition, an edge-latched history, a maskable interrupt flag, and a persistent flag. The live view follows the input directly. The other three views hold state and are cleared by reading them, each under its own rule.

Software reads a view by placing a 2-bit view address on the read port together with a one-cycle strobe. The value comes back on the next cycle. A per-alarm mask register, loaded through a write strobe, decides which alarms may raise interrupt flags. One request line is raised while any flag whose alarm is currently unmasked is set.

The persistent view sets on the level of an alarm. A read clears a persistent bit only if that alarm is inactive at the moment of the read, so a condition that is still present cannot be cleared.

Top module: `alarm_view_bank`

## Requirements
- R1: A read with view address 0 returns the alarm input vector as it stood in the strobe cycle.
- R2: A latched-view bit sets when its alarm rises (1 now, 0 in the previous cycle). A read with view address 1 clears the latched view. A rise in the same cycle as that read leaves the bit set.
- R3: An interrupt-view bit sets on a rise of its alarm only when that alarm's mask bit is 0. A mask bit of 1 means masked.
- R4: A read with view address 2 clears the interrupt view. A rise that is allowed to set a bit in the same cycle as the read leaves that bit set.
- R5: `irq_o` is 1 exactly when some interrupt-view bit is set and its current mask bit is 0.
- R6: A persistent-view bit is set in every cycle after one in which its alarm is 1. A read with view address 3 clears only those bits whose alarm is 0 in the read cycle.
- R7: Read data changes one cycle after a strobe and holds its value until the next strobe. It shows the addressed view as it was before any clear caused by that same read.
- R8: Reset clears the latched, interrupt and persistent views, the read data and the edge history, and sets every mask bit to 1. An alarm that is 1 in the first cycle after reset therefore counts as a rise.
- R9: A mask write takes effect for rises in the cycles after the write cycle. A rise in the write cycle itself is judged against the previous mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| alarm_i | input | N_ALARM | Alarm condition vector, 1 = active |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | N_ALARM | New mask value, 1 = masked |
| rd_stb_i | input | 1 | Single-cycle read strobe |
| rd_addr_i | input | 2 | View select: 0 live, 1 latched, 2 interrupt, 3 persistent |
| rd_data_o | output | N_ALARM | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the bank with N_ALARM = 4. With that width it can apply every pair of consecutive alarm vectors (16 × 16), followed by a read of each of the four views. This covers every combination of rise, steady level and fall together with every clear-on-read rule, including a rise or a still-active alarm in the read cycle. The sweep is repeated under four mask values: the reset mask with no write, all unmasked, and the two alternating patterns. This shows the masking behaviour per bit and the moment at which a mask write takes effect.

// File: rtl/alarm_bank_pkg.sv
package alarm_bank_pkg;

    typedef enum logic [1:0] {
        VIEW_LIVE = 2'd0,
        VIEW_LAT  = 2'd1,
        VIEW_INT  = 2'd2,
        VIEW_PERS = 2'd3
    } view_e;

    typedef struct packed {
        logic prev;
        logic lat;
        logic intr;
        logic pers;
    } cell_t;

endpackage

// File: rtl/alarm_bit_cell.sv
module alarm_bit_cell
    import alarm_bank_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic alarm_i,
    input  logic mask_i,
    input  logic clr_lat_i,
    input  logic clr_int_i,
    input  logic clr_pers_i,
    output logic lat_o,
    output logic int_o,
    output logic pers_o
);

    cell_t cell_d, cell_q;
    logic  rise;

    always_comb begin
        rise         = alarm_i & ~cell_q.prev;
        cell_d.prev  = alarm_i;
        // edge-set, clear on read, set wins
        cell_d.lat   = (cell_q.lat & ~clr_lat_i) | rise;
        // edge-set when unmasked, clear on read, set wins
        cell_d.intr  = (cell_q.intr & ~clr_int_i) | (rise & ~mask_i);
        // level-set; read clears only while the condition is absent
        cell_d.pers  = alarm_i | (cell_q.pers & ~(clr_pers_i & ~alarm_i));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cell_q <= '0;
        else         cell_q <= cell_d;
    end

    assign lat_o  = cell_q.lat;
    assign int_o  = cell_q.intr;
    assign pers_o = cell_q.pers;

endmodule

// File: rtl/alarm_view_mux.sv
module alarm_view_mux
    import alarm_bank_pkg::*;
#(
    parameter int N_ALARM = 8
) (
    input  view_e              sel_i,
    input  logic [N_ALARM-1:0] live_i,
    input  logic [N_ALARM-1:0] lat_i,
    input  logic [N_ALARM-1:0] int_i,
    input  logic [N_ALARM-1:0] pers_i,
    output logic [N_ALARM-1:0] data_o
);

    always_comb begin
        unique case (sel_i)
            VIEW_LIVE: data_o = live_i;
            VIEW_LAT:  data_o = lat_i;
            VIEW_INT:  data_o = int_i;
            default:   data_o = pers_i;
        endcase
    end

endmodule

// File: rtl/alarm_view_bank.sv
module alarm_view_bank
    import alarm_bank_pkg::*;
#(
    parameter int N_ALARM = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_ALARM-1:0] alarm_i,
    input  logic               mask_we_i,
    input  logic [N_ALARM-1:0] mask_wdata_i,
    input  logic               rd_stb_i,
    input  logic [1:0]         rd_addr_i,
    output logic [N_ALARM-1:0] rd_data_o,
    output logic               irq_o
);

    localparam logic [N_ALARM-1:0] MASK_ALL = {N_ALARM{1'b1}};

    typedef struct packed {
        logic [N_ALARM-1:0] mask;
        logic [N_ALARM-1:0] rd;
    } top_t;

    top_t st_d, st_q;

    view_e              sel;
    logic               clr_lat, clr_int, clr_pers;
    logic [N_ALARM-1:0] lat_vec, int_vec, pers_vec, mask_cur, mux_data;

    assign sel      = view_e'(rd_addr_i);
    assign clr_lat  = rd_stb_i && (sel == VIEW_LAT);
    assign clr_int  = rd_stb_i && (sel == VIEW_INT);
    assign clr_pers = rd_stb_i && (sel == VIEW_PERS);
    assign mask_cur = st_q.mask;

    for (genvar i = 0; i < N_ALARM; i++) begin : g_cell
        alarm_bit_cell u_cell (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .alarm_i    (alarm_i[i]),
            .mask_i     (st_q.mask[i]),
            .clr_lat_i  (clr_lat),
            .clr_int_i  (clr_int),
            .clr_pers_i (clr_pers),
            .lat_o      (lat_vec[i]),
            .int_o      (int_vec[i]),
            .pers_o     (pers_vec[i])
        );
    end

    alarm_view_mux #(.N_ALARM(N_ALARM)) u_mux (
        .sel_i  (sel),
        .live_i (alarm_i),
        .lat_i  (lat_vec),
        .int_i  (int_vec),
        .pers_i (pers_vec),
        .data_o (mux_data)
    );

    always_comb begin
        st_d      = st_q;
        if (mask_we_i) st_d.mask = mask_wdata_i;
        if (rd_stb_i)  st_d.rd   = mux_data;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.mask <= MASK_ALL;
            st_q.rd   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.rd;
    assign irq_o     = |(int_vec & ~st_q.mask);

endmodule

// File: rtl/alarm_view_chk.sv
module alarm_view_chk #(
    parameter int N_ALARM = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [N_ALARM-1:0] alarm_i,
    input logic               rd_stb_i,
    input logic [1:0]         rd_addr_i,
    input logic [N_ALARM-1:0] rd_data_o,
    input logic               irq_o,
    input logic [N_ALARM-1:0] mask_cur,
    input logic [N_ALARM-1:0] lat_vec,
    input logic [N_ALARM-1:0] int_vec,
    input logic [N_ALARM-1:0] pers_vec
);

    logic [N_ALARM-1:0] prev_c;
    logic [N_ALARM-1:0] rise_c;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_c <= '0;
        else         prev_c <= alarm_i;
    end

    assign rise_c = alarm_i & ~prev_c;

    assert_lat_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((lat_vec & $past(rise_c)) == $past(rise_c)));

    assert_int_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((int_vec & ~$past(int_vec) & $past(mask_cur)) == '0));

    assert_int_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stb_i && rd_addr_i == 2'd2 && rise_c == '0) |=> (int_vec == '0));

    assert_irq_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_vec == '0) |-> !irq_o);

    assert_pers_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((pers_vec & $past(alarm_i)) == $past(alarm_i)));

    assert_pers_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stb_i && rd_addr_i == 2'd3 && alarm_i == '0) |=> (pers_vec == '0));

    assert_rd_preclear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stb_i && rd_addr_i == 2'd1) |=> (rd_data_o == $past(lat_vec)));

    assert_rd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_stb_i |=> $stable(rd_data_o));

endmodule

bind alarm_view_bank alarm_view_chk #(.N_ALARM(N_ALARM)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alarm_i   (alarm_i),
    .rd_stb_i  (rd_stb_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .mask_cur  (mask_cur),
    .lat_vec   (lat_vec),
    .int_vec   (int_vec),
    .pers_vec  (pers_vec)
);

// File: tb/sim_alarm_view_bank.sv
module sim_alarm_view_bank;

    localparam int NA = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NA-1:0] alarm = '0;
    logic          mask_we = 1'b0;
    logic [NA-1:0] mask_wd = '0;
    logic          rd_stb = 1'b0;
    logic [1:0]    rd_addr = '0;
    logic [NA-1:0] rd_data;
    logic          irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    logic [NA-1:0] m_prev, m_lat, m_int, m_pers, m_mask, m_rd;
    string         rd_tag = "R8";

    always #4 clk = ~clk;

    alarm_view_bank #(.N_ALARM(NA)) u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .alarm_i      (alarm),
        .mask_we_i    (mask_we),
        .mask_wdata_i (mask_wd),
        .rd_stb_i     (rd_stb),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .irq_o        (irq)
    );

    task automatic check(input string tag, input logic [NA-1:0] act, input logic [NA-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [NA-1:0] a, input logic we, input logic [NA-1:0] wd,
                        input logic stb, input logic [1:0] ad);
        logic [NA-1:0] rise;
        alarm   = a;
        mask_we = we;
        mask_wd = wd;
        rd_stb  = stb;
        rd_addr = ad;
        rise    = a & ~m_prev;
        if (stb) begin
            case (ad)
                2'd0: begin m_rd = a;      rd_tag = "R1/R7"; end
                2'd1: begin m_rd = m_lat;  rd_tag = "R2/R7"; end
                2'd2: begin m_rd = m_int;  rd_tag = "R3/R4/R7"; end
                default: begin m_rd = m_pers; rd_tag = "R6/R7"; end
            endcase
        end else begin
            rd_tag = "R7";
        end
        m_lat  = ((stb && ad == 2'd1) ? '0 : m_lat) | rise;
        m_int  = ((stb && ad == 2'd2) ? '0 : m_int) | (rise & ~m_mask);
        m_pers = (stb && ad == 2'd3) ? ((m_pers & a) | a) : (m_pers | a);
        if (we) m_mask = wd;
        m_prev = a;
        @(posedge clk);
        @(negedge clk);
        check(rd_tag, rd_data, m_rd);
        check("R5/R9", {{(NA-1){1'b0}}, irq}, {{(NA-1){1'b0}}, |(m_int & ~m_mask)});
    endtask

    initial begin
        m_prev = '0; m_lat = '0; m_int = '0; m_pers = '0; m_mask = '1; m_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", rd_data, '0);
        check("R8", {{(NA-1){1'b0}}, irq}, '0);
        for (int v = 1; v < 4; v++) step('0, 1'b0, '0, 1'b1, 2'(v));
        for (int pass = 0; pass < 4; pass++) begin
            if (pass == 1) step('0, 1'b1, 4'h0, 1'b0, 2'd0);
            if (pass == 2) step('0, 1'b1, 4'h5, 1'b0, 2'd0);
            if (pass == 3) step('0, 1'b1, 4'hA, 1'b0, 2'd0);
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    for (int ad = 0; ad < 4; ad++) begin
                        step(4'(a), 1'b0, '0, 1'b0, 2'd0);
                        step(4'(b), 1'b0, '0, 1'b1, 2'(ad));
                    end
                end
            end
        end
        // R9: mask write in the same cycle as a rise uses the old mask
        step('0, 1'b1, 4'hF, 1'b1, 2'd2);
        step(4'h3, 1'b1, 4'h0, 1'b0, 2'd0);
        step(4'h3, 1'b0, '0, 1'b1, 2'd2);
        step('0, 1'b0, '0, 1'b0, 2'd0);
        step(4'hC, 1'b0, '0, 1'b1, 2'd2);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule